// File: doc/BRIEF.md
# Microcode Triad Sequence-Word Executor

This block carries out the control part of one microcode sequence word. The word is attached to a group of three micro-operation slots, called a triad. The word holds three 2-bit slot pointers, one for each of three actions: flow control, jump and synchronization. Each pointer names the slot after whose completion its action runs. The word also carries a 2-bit check code. When the check code is wrong, the whole triad is neutralised.

The host starts a flow by loading a start address. After that it presents one sequence word per triad while the block is idle and not halted. The triad address is the current fetch address. The host then pulses the per-slot completion lines as the slots retire, in slot order, at most one per cycle. Each action comes out as a one-cycle strobe in the cycle after its slot completes. The next fetch address is settled in the cycle after slot 2 completes. Two save registers hold return addresses for the save and return actions.

Top module: `useq_triad_exec`

## Requirements
- R1: After reset, `fetch_addr` is 0, `seq_halted` and `chk_err` are 0, and every strobe and request output is 0.
- R2: Word layout:
  - `[1:0]` is the flow pointer, `[3:2]` the jump pointer and `[5:4]` the sync pointer.
  - `[9:6]` is the flow code, `[12:10]` the sync code and `[12+AW:13]` the jump address.
  - Bits `[14+AW:13+AW]` hold the check code. Its bit 0 is the XOR of the even-indexed payload bits and its bit 1 the XOR of the odd-indexed payload bits.
  - On a mismatch, `chk_err` is 1 from the cycle after the load until the next load or start. No strobe, jump or sync comes out for that triad, and the next fetch address is the triad address plus one.
- R3: Flow codes are:
  - 0 no-op; 1 and 2 return via save register 0 and 1; 3 and 4 save into register 0 and 1; 5 and 6 save with register override into register 0 and 1.
  - 7 tag write, 8 loop, 9 stop, 10 to 13 end variants 0 to 3.
  - 14 and 15 are reserved no-ops.
  - For codes 1 to 13, `flow_stb[code]` pulses for one cycle, in the cycle after the slot named by the flow pointer completes. A flow pointer of 3 gives no flow action.
- R4: A save code writes the triad address plus one into its save register. A return code makes that register's value the next fetch address.
- R5: A jump request with target `jump_tgt` pulses in the cycle after the slot named by the jump pointer completes, and the target becomes the next fetch address. With a jump pointer of 3 the jump address is ignored.
- R6: While `cond_en` is 1 at the triggering completion, the jump is taken only if `cond_flag` is 1. Otherwise fetch continues with the triad address plus one.
- R7: When the flow and jump pointers name the same slot, the flow action is applied first, so a taken jump overrides a return in the same triad.
- R8: `sync_req` pulses with `sync_code` and `sync_slot` in the cycle after the slot named by the sync pointer completes. Sync codes 1 to 7 are load-fence wait, load-fence mark, load-fence wait-and-mark, full sync, sync wait, sync mark and sync wait-and-mark. A sync pointer of 3 or a sync code of 0 gives no request.
- R9: An end code:
  - pulses `done_stb` with `done_kind` equal to the variant and sets `seq_halted`;
  - suppresses any jump in the same or a later slot of that triad;
  - keeps `fetch_addr` unchanged.
  While halted, word loads and completion pulses have no effect.
- R10: With no taken jump, no return and no end, `fetch_addr` becomes the triad address plus one in the cycle after slot 2 completes.
- R11: A `start` pulse makes `fetch_addr` equal `start_addr` in the next cycle and clears `seq_halted` and `chk_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load a new start address and leave the halted state |
| start_addr | input | AW | Start address |
| word_load | input | 1 | Present a sequence word for the triad at `fetch_addr` |
| seq_word | input | AW+15 | Sequence word: payload plus check code |
| slot_done | input | 3 | One-hot completion pulse of slot 0, 1 or 2 |
| cond_en | input | 1 | The jump of this triad is conditional |
| cond_flag | input | 1 | Condition from the latest state test |
| fetch_addr | output | AW | Next fetch address |
| seq_halted | output | 1 | Sequencing frozen after an end action |
| chk_err | output | 1 | Check code mismatch on the current word |
| flow_stb | output | 16 | One-hot flow action strobe indexed by flow code |
| done_stb | output | 1 | End-of-flow strobe |
| done_kind | output | 2 | End variant |
| jump_req | output | 1 | Taken jump strobe |
| jump_tgt | output | AW | Jump target |
| sync_req | output | 1 | Synchronization request strobe |
| sync_code | output | 3 | Synchronization action code |
| sync_slot | output | 2 | Slot the synchronization applies to |

## Verification
The triads place the three pointers on distinct slots, on a shared slot, and at the disabling value 3.

- Distinct slots show that each strobe follows its own slot.
- A shared slot with a return and a jump shows the order in which they are applied.
- The value 3 shows that the ignored fields stay silent.

Conditional jumps are run with the flag both low and high, to tell a taken jump from sequential fetch. A word with a corrupted check code, an end action that shares its slot with a jump, and loads issued while halted show the suppression paths. A later return proves that save contents survive across a restart.

// File: rtl/useq_pkg.sv
// Package: shared encodings and sequence-word field offsets for the
// triad executor. Assumes a 2-bit pointer where 3 means "no slot".
package useq_pkg;
    localparam logic [1:0] PTR_NONE = 2'd3;

    // Field offsets inside the sequence-word payload
    localparam int OFF_PF = 0;   // flow pointer
    localparam int OFF_PJ = 2;   // jump pointer
    localparam int OFF_PS = 4;   // sync pointer
    localparam int OFF_FL = 6;   // flow code (4 bits)
    localparam int OFF_SY = 10;  // sync code (3 bits)
    localparam int OFF_JA = 13;  // jump address (AW bits)

    typedef enum logic [3:0] {
        FL_NOP    = 4'd0,
        FL_RET0   = 4'd1,
        FL_RET1   = 4'd2,
        FL_SAVE0  = 4'd3,
        FL_SAVE1  = 4'd4,
        FL_SAVEX0 = 4'd5,
        FL_SAVEX1 = 4'd6,
        FL_TAGW   = 4'd7,
        FL_LOOP   = 4'd8,
        FL_STOP   = 4'd9,
        FL_END0   = 4'd10,
        FL_END1   = 4'd11,
        FL_END2   = 4'd12,
        FL_END3   = 4'd13,
        FL_RSV14  = 4'd14,
        FL_RSV15  = 4'd15
    } flow_op_e;

    typedef enum logic [2:0] {
        SY_NONE   = 3'd0,
        SY_LF_WT  = 3'd1,
        SY_LF_MK  = 3'd2,
        SY_LF_WM  = 3'd3,
        SY_FULL   = 3'd4,
        SY_WT     = 3'd5,
        SY_MK     = 3'd6,
        SY_WM     = 3'd7
    } sync_op_e;

    // Flow codes that produce a strobe (1..13)
    localparam logic [15:0] FLOW_LIVE = 16'b0011_1111_1111_1110;
endpackage

// File: rtl/useq_crc_chk.sv
// Check-code verifier: recomputes the two parity bits of the payload
// (even-indexed and odd-indexed bits) and flags a mismatch.
// Assumes the check code sits in the two bits above the payload.
module useq_crc_chk #(
    parameter int PW = 25
) (
    input  logic [PW+1:0] word,
    output logic          bad
);
    logic par_even;
    logic par_odd;

    // Fold payload bits into the two parity accumulators
    always_comb begin
        par_even = 1'b0;
        par_odd  = 1'b0;
        for (int i = 0; i < PW; i++) begin
            if (i % 2 == 0) par_even = par_even ^ word[i];
            else            par_odd  = par_odd  ^ word[i];
        end
        bad = (par_even != word[PW]) || (par_odd != word[PW+1]);
    end
endmodule

// File: rtl/useq_slot_trigger.sv
// Slot trigger: fires when the slot named by a 2-bit pointer completes.
// Assumes slot_done is one-hot or zero; pointer value 3 never fires.
module useq_slot_trigger (
    input  logic       active,
    input  logic [1:0] ptr,
    input  logic [2:0] slot_done,
    output logic       fire
);
    logic [3:0] done_ext;

    // Pad the completion vector so pointer 3 selects a constant zero
    always_comb begin
        done_ext = {1'b0, slot_done};
        fire     = active && done_ext[ptr];
    end
endmodule

// File: rtl/useq_save_regs.sv
// Save-register file: holds return addresses written by save actions and
// read combinationally by return actions. One write per cycle at most.
module useq_save_regs #(
    parameter int AW = 12,
    parameter int N  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [SEL_W-1:0]     wsel,
    input  logic [AW-1:0]        wdata,
    input  logic [SEL_W-1:0]     rsel,
    output logic [AW-1:0]        rdata
);
    localparam int SEL_W = (N > 1) ? $clog2(N) : 1;

    logic [AW-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        // Capture a return address when this register is selected
        always_ff @(posedge clk) begin
            if (!rst_n)                          regs[g] <= '0;
            else if (we && wsel == SEL_W'(g))    regs[g] <= wdata;
        end
    end

    // Read port for return actions
    always_comb rdata = regs[rsel];
endmodule

// File: rtl/useq_triad_exec.sv
// Triad sequence-word executor: latches a sequence word for the triad at
// the current fetch address, runs its flow, jump and sync actions after
// their pointed slots complete, and settles the next fetch address after
// slot 2. Assumes slot completions arrive in order 0,1,2, one per cycle.
module useq_triad_exec
    import useq_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    start_addr,
    input  logic             word_load,
    input  logic [AW+14:0]   seq_word,
    input  logic [2:0]       slot_done,
    input  logic             cond_en,
    input  logic             cond_flag,
    output logic [AW-1:0]    fetch_addr,
    output logic             seq_halted,
    output logic             chk_err,
    output logic [15:0]      flow_stb,
    output logic             done_stb,
    output logic [1:0]       done_kind,
    output logic             jump_req,
    output logic [AW-1:0]    jump_tgt,
    output logic             sync_req,
    output logic [2:0]       sync_code,
    output logic [1:0]       sync_slot
);
    localparam int PW = OFF_JA + AW;
    localparam int NACT = 3;

    logic [PW-1:0]   word_q;
    logic [AW-1:0]   tri_q;
    logic [AW-1:0]   nxt_q;
    logic            active_q;
    logic            bad_c;

    logic [NACT-1:0][1:0] ptr_v;
    logic [NACT-1:0]      fire_v;
    logic            go_flow, go_jump, go_sync;
    flow_op_e        flow_c;
    logic [2:0]      sync_c;
    logic [AW-1:0]   jaddr_c;

    logic            save_we;
    logic            save_wsel;
    logic            save_rsel;
    logic [AW-1:0]   save_rd;
    logic            ret_c;
    logic            end_c;
    logic            take_c;
    logic [AW-1:0]   nxt_c;
    logic [3:0]      end_var;

    useq_crc_chk #(.PW(PW)) u_crc (
        .word (seq_word),
        .bad  (bad_c)
    );

    // Pointer order: 0 flow, 1 jump, 2 sync
    always_comb begin
        ptr_v[0] = word_q[OFF_PF +: 2];
        ptr_v[1] = word_q[OFF_PJ +: 2];
        ptr_v[2] = word_q[OFF_PS +: 2];
        flow_c   = flow_op_e'(word_q[OFF_FL +: 4]);
        sync_c   = word_q[OFF_SY +: 3];
        jaddr_c  = word_q[OFF_JA +: AW];
    end

    for (genvar g = 0; g < NACT; g++) begin : g_trig
        useq_slot_trigger u_trig (
            .active    (active_q),
            .ptr       (ptr_v[g]),
            .slot_done (slot_done),
            .fire      (fire_v[g])
        );
    end

    // A failed check code silences every action of the triad
    always_comb begin
        go_flow = fire_v[0] && !chk_err;
        go_jump = fire_v[1] && !chk_err;
        go_sync = fire_v[2] && !chk_err && (sync_c != SY_NONE);
    end

    useq_save_regs #(.AW(AW), .N(2)) u_save (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (save_we && !start),
        .wsel  (save_wsel),
        .wdata (tri_q + AW'(1)),
        .rsel  (save_rsel),
        .rdata (save_rd)
    );

    // Decode the flow action, then apply the jump on top of it
    always_comb begin
        save_we   = 1'b0;
        save_wsel = 1'b0;
        save_rsel = 1'b0;
        ret_c     = 1'b0;
        end_c     = 1'b0;
        end_var   = 4'(flow_c) - 4'(FL_END0);
        if (go_flow) begin
            case (flow_c)
                FL_RET0, FL_RET1: begin
                    ret_c     = 1'b1;
                    save_rsel = (flow_c == FL_RET1);
                end
                FL_SAVE0, FL_SAVE1, FL_SAVEX0, FL_SAVEX1: begin
                    save_we   = 1'b1;
                    save_wsel = (flow_c == FL_SAVE1) || (flow_c == FL_SAVEX1);
                end
                FL_END0, FL_END1, FL_END2, FL_END3: end_c = 1'b1;
                default: ;
            endcase
        end
        nxt_c = ret_c ? save_rd : nxt_q;
        take_c = go_jump && !end_c && !seq_halted && (!cond_en || cond_flag);
        if (take_c) nxt_c = jaddr_c;
    end

    // Sequencing state, action strobes and fetch address update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q     <= '0;
            tri_q      <= '0;
            nxt_q      <= '0;
            active_q   <= 1'b0;
            fetch_addr <= '0;
            seq_halted <= 1'b0;
            chk_err    <= 1'b0;
            flow_stb   <= '0;
            done_stb   <= 1'b0;
            done_kind  <= '0;
            jump_req   <= 1'b0;
            jump_tgt   <= '0;
            sync_req   <= 1'b0;
            sync_code  <= '0;
            sync_slot  <= '0;
        end else begin
            flow_stb <= '0;
            done_stb <= 1'b0;
            jump_req <= 1'b0;
            sync_req <= 1'b0;
            if (start) begin
                fetch_addr <= start_addr;
                seq_halted <= 1'b0;
                active_q   <= 1'b0;
                chk_err    <= 1'b0;
            end else if (word_load && !active_q && !seq_halted) begin
                word_q   <= seq_word[PW-1:0];
                tri_q    <= fetch_addr;
                nxt_q    <= fetch_addr + AW'(1);
                active_q <= 1'b1;
                chk_err  <= bad_c;
            end else if (active_q && (slot_done != 3'b000)) begin
                nxt_q <= nxt_c;
                if (go_flow) flow_stb <= FLOW_LIVE & (16'd1 << flow_c);
                if (end_c) begin
                    done_stb   <= 1'b1;
                    done_kind  <= end_var[1:0];
                    seq_halted <= 1'b1;
                end
                if (take_c) begin
                    jump_req <= 1'b1;
                    jump_tgt <= jaddr_c;
                end
                if (go_sync) begin
                    sync_req  <= 1'b1;
                    sync_code <= sync_c;
                    sync_slot <= ptr_v[2];
                end
                if (slot_done[2]) begin
                    active_q <= 1'b0;
                    if (!end_c && !seq_halted) fetch_addr <= nxt_c;
                end
            end
        end
    end
endmodule

// File: rtl/useq_triad_exec_chk.sv
// Checker for the triad executor: port-level timing and exclusivity rules.
module useq_triad_exec_chk #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [AW-1:0] start_addr,
    input logic [AW-1:0] fetch_addr,
    input logic          seq_halted,
    input logic          chk_err,
    input logic [15:0]   flow_stb,
    input logic          done_stb,
    input logic          jump_req,
    input logic          sync_req,
    input logic [2:0]    sync_code,
    input logic [1:0]    sync_slot
);
    p_flow_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flow_stb));

    p_reserved_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !flow_stb[0] && !flow_stb[14] && !flow_stb[15]);

    p_err_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chk_err |-> (flow_stb == 16'd0) && !jump_req && !sync_req && !done_stb);

    p_sync_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req |-> (sync_slot != 2'd3) && (sync_code != 3'd0));

    p_done_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_stb |-> seq_halted && flow_stb[13:10] != 4'd0);

    p_halt_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_halted && !start) |=> $stable(fetch_addr));

    p_start_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (fetch_addr == $past(start_addr)) && !seq_halted && !chk_err);
endmodule

bind useq_triad_exec useq_triad_exec_chk #(.AW(AW)) u_chk (.*);

// File: tb/useq_triad_exec_bench.sv
// Scoreboard bench: driver tasks model each triad and queue the expected
// outputs per cycle; a monitor pops and compares them at negedges.
module useq_triad_exec_bench;
    localparam int AW = 12;
    localparam int PW = 13 + AW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [AW-1:0]   start_addr = '0;
    logic            word_load = 1'b0;
    logic [PW+1:0]   seq_word = '0;
    logic [2:0]      slot_done = '0;
    logic            cond_en = 1'b0;
    logic            cond_flag = 1'b0;
    logic [AW-1:0]   fetch_addr;
    logic            seq_halted, chk_err, done_stb, jump_req, sync_req;
    logic [15:0]     flow_stb;
    logic [1:0]      done_kind, sync_slot;
    logic [AW-1:0]   jump_tgt;
    logic [2:0]      sync_code;

    useq_triad_exec #(.AW(AW)) u_useq_triad_exec (.*);

    always #10 clk = ~clk;  // 50 MHz

    typedef struct {
        int            due;
        logic [15:0]   fs;
        logic          dn;
        logic [1:0]    dk;
        logic          jr;
        logic [AW-1:0] jt;
        logic          sr;
        logic [2:0]    sc;
        logic [1:0]    ss;
        logic [AW-1:0] fa;
        logic          hl;
        logic          er;
        string         tag;
    } exp_t;

    exp_t q[$];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // model state
    logic [AW-1:0] m_fetch = '0;
    logic [AW-1:0] m_save[2] = '{default: '0};
    logic          m_halt = 1'b0;
    logic          m_err = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [PW+1:0] mkword(input logic [1:0] pf, input logic [1:0] pj,
            input logic [1:0] ps, input logic [3:0] fl, input logic [2:0] sy,
            input logic [AW-1:0] ja, input bit corrupt);
        logic [PW-1:0] p;
        logic e, o;
        p = {ja, sy, fl, ps, pj, pf};
        e = 1'b0; o = 1'b0;
        for (int i = 0; i < PW; i++) begin
            if (i % 2 == 0) e ^= p[i]; else o ^= p[i];
        end
        if (corrupt) e = ~e;
        return {o, e, p};
    endfunction

    function automatic exp_t blank(input string tag);
        exp_t x;
        x.due = cyc + 1; x.fs = '0; x.dn = 0; x.dk = '0; x.jr = 0; x.jt = '0;
        x.sr = 0; x.sc = '0; x.ss = '0; x.fa = m_fetch; x.hl = m_halt;
        x.er = m_err; x.tag = tag;
        return x;
    endfunction

    task automatic do_start(input logic [AW-1:0] a, input string tag);
        @(posedge clk); #1;
        start = 1'b1; start_addr = a;
        m_fetch = a; m_halt = 0; m_err = 0;
        q.push_back(blank(tag));
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic run_triad(input logic [1:0] pf, input logic [1:0] pj,
            input logic [1:0] ps, input logic [3:0] fl, input logic [2:0] sy,
            input logic [AW-1:0] ja, input bit cen, input bit cfl,
            input bit corrupt, input string tag);
        logic [AW-1:0] tri_a, nxt;
        bit loaded;
        exp_t x;
        @(posedge clk); #1;
        word_load = 1'b1;
        seq_word = mkword(pf, pj, ps, fl, sy, ja, corrupt);
        loaded = !m_halt;
        tri_a = m_fetch;
        nxt = m_fetch + AW'(1);
        @(posedge clk); #1;
        word_load = 1'b0;
        if (loaded) m_err = corrupt;
        cond_en = cen; cond_flag = cfl;
        for (int k = 0; k < 3; k++) begin
            slot_done = 3'(1 << k);
            if (loaded && !m_err) begin
                x = blank(tag);
                if (pf == 2'(k) && fl >= 4'd1 && fl <= 4'd13) begin
                    x.fs[fl] = 1'b1;
                    if (fl == 4'd1 || fl == 4'd2) nxt = m_save[fl == 4'd2];
                    if (fl >= 4'd3 && fl <= 4'd6) m_save[fl == 4'd4 || fl == 4'd6] = tri_a + AW'(1);
                    if (fl >= 4'd10) begin
                        x.dn = 1; x.dk = 2'(fl - 4'd10); m_halt = 1;
                    end
                end
                if (pj == 2'(k) && !m_halt && (!cen || cfl)) begin
                    x.jr = 1; x.jt = ja; nxt = ja;
                end
                if (ps == 2'(k) && sy != 3'd0) begin
                    x.sr = 1; x.sc = sy; x.ss = 2'(k);
                end
                if (k == 2 && !m_halt) m_fetch = nxt;
            end else begin
                if (k == 2 && loaded) m_fetch = tri_a + AW'(1);
            end
            x = (loaded && !m_err) ? x : blank(tag);
            x.fa = m_fetch; x.hl = m_halt; x.er = m_err;
            q.push_back(x);
            @(posedge clk); #1;
        end
        slot_done = 3'b000;
        cond_en = 0; cond_flag = 0;
    endtask

    // Monitor: compare expected items when they fall due
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t x;
            bit ok;
            x = q.pop_front();
            checks++;
            ok = (flow_stb == x.fs) && (done_stb == x.dn) && (!x.dn || done_kind == x.dk)
                 && (jump_req == x.jr) && (!x.jr || jump_tgt == x.jt)
                 && (sync_req == x.sr) && (!x.sr || (sync_code == x.sc && sync_slot == x.ss))
                 && (fetch_addr == x.fa) && (seq_halted == x.hl) && (chk_err == x.er);
            if (!ok) begin
                errors++;
                $display("FAIL %s: act fs=%h dn=%b dk=%0d jr=%b jt=%h sr=%b sc=%0d ss=%0d fa=%h hl=%b er=%b exp fs=%h dn=%b dk=%0d jr=%b jt=%h sr=%b sc=%0d ss=%0d fa=%h hl=%b er=%b",
                    x.tag, flow_stb, done_stb, done_kind, jump_req, jump_tgt, sync_req,
                    sync_code, sync_slot, fetch_addr, seq_halted, chk_err,
                    x.fs, x.dn, x.dk, x.jr, x.jt, x.sr, x.sc, x.ss, x.fa, x.hl, x.er);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: act running exp done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;  // R1 reset state
        if (fetch_addr != '0 || seq_halted || chk_err || flow_stb != '0 || done_stb
            || jump_req || sync_req) begin
            errors++;
            $display("FAIL R1 reset: act fa=%h hl=%b er=%b fs=%h exp all zero",
                fetch_addr, seq_halted, chk_err, flow_stb);
        end
        do_start(12'h100, "R11 start");
        run_triad(2'd0, 2'd3, 2'd1, 4'd3, 3'd4, 12'hABC, 0, 0, 0, "R4 save0 R5 ptr3 R8 sync R10");
        run_triad(2'd1, 2'd2, 2'd3, 4'd4, 3'd7, 12'h200, 0, 0, 0, "R4 save1 R5 jump R8 ptr3");
        run_triad(2'd2, 2'd3, 2'd3, 4'd1, 3'd0, 12'h000, 0, 0, 0, "R4 ret0");
        run_triad(2'd2, 2'd2, 2'd3, 4'd2, 3'd0, 12'h300, 0, 0, 0, "R7 ret1 vs jump");
        run_triad(2'd0, 2'd1, 2'd0, 4'd7, 3'd1, 12'h050, 1, 0, 0, "R6 cond false R3 tagw");
        run_triad(2'd1, 2'd0, 2'd2, 4'd8, 3'd6, 12'h060, 1, 1, 0, "R6 cond true R3 loop");
        run_triad(2'd0, 2'd1, 2'd2, 4'd9, 3'd3, 12'h777, 0, 0, 1, "R2 bad check");
        run_triad(2'd1, 2'd3, 2'd0, 4'd5, 3'd0, 12'h000, 0, 0, 0, "R4 savex0 R8 code0");
        run_triad(2'd3, 2'd3, 2'd1, 4'd9, 3'd0, 12'h000, 0, 0, 0, "R3 ptr3");
        run_triad(2'd0, 2'd3, 2'd3, 4'd14, 3'd0, 12'h000, 0, 0, 0, "R3 reserved");
        run_triad(2'd2, 2'd3, 2'd2, 4'd6, 3'd2, 12'h000, 0, 0, 0, "R4 savex1 R3 stop-free");
        run_triad(2'd0, 2'd3, 2'd3, 4'd9, 3'd0, 12'h000, 0, 0, 0, "R3 stop");
        run_triad(2'd1, 2'd1, 2'd2, 4'd12, 3'd5, 12'h3FF, 0, 0, 0, "R9 end2 over jump");
        run_triad(2'd0, 2'd0, 2'd0, 4'd3, 3'd4, 12'h123, 0, 0, 0, "R9 ignored while halted");
        do_start(12'h010, "R11 restart");
        run_triad(2'd0, 2'd3, 2'd3, 4'd1, 3'd0, 12'h000, 0, 0, 0, "R4 ret0 after restart");
        run_triad(2'd2, 2'd1, 2'd3, 4'd10, 3'd0, 12'h0AA, 0, 0, 0, "R9 end0 after jump");
        wait (q.size() == 0);
        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule